// File: doc/BRIEF.md
# Serial Converter Readout Sequencer

This block is the digital front end of a converter that reports its results over a three-wire serial link. The host drives an active-low select line and a slow serial clock. The block returns the previously stored 10-bit result on a serial data line, most significant bit first, together with an enable for the line's output driver. Both host inputs are brought into a free-running system clock domain. Falling edges of the serial clock are detected there, and every select transition must pass a stability filter before the block acts on it.

The block counts serial clock falling edges. It opens a sampling window on the third edge and closes it on the tenth. On the tenth edge it also pulses a start request to an external conversion engine, and the engine later returns a done strobe with the new result. From the tenth edge onward the data line carries zeros, so frames of 11 to 16 clocks end in zero fill.

When select stays low between frames, the next frame starts by itself:
- If no further clock arrives within a timeout, the frame is treated as a 10-clock frame. The new result appears as soon as the conversion finishes.
- If a further rising edge arrives within the timeout, the frame is treated as a 16-clock frame. The new result appears at the sixteenth falling edge.

A clock that arrives late, while the conversion is still running, sends the block into a lost-sync state. Only a new select cycle clears that state. Selecting again while a conversion is in flight aborts the conversion, and the stored result is kept.

Top module: `adc_serial_seq`

## Requirements
- R1: While select is not qualified low, `sdo_en` is 0, `sdo` is 0, and serial clock edges do not advance the frame: the next frame still starts with the stored most significant bit.
- R2: After a qualified select, `sdo` shows bit 9 of the stored result. After falling edge k (k = 1..9) it shows bit 9-k, so bit 0 follows the ninth edge.
- R3: After falling edges 10 through 15 of a frame, `sdo` is 0. The internal edge count never exceeds 16.
- R4: `sample_en` is 0 after falling edges 1 and 2, is 1 after edges 3 through 9, and drops at edge 10. At edge 10 `conv_start` pulses for exactly one system clock, and it does not pulse earlier in the frame.
- R5: A frame that is deselected before its tenth falling edge produces no `conv_start` and leaves the stored result unchanged.
- R6: A select change is accepted only after the synchronised level has differed from the accepted level for CS_HOLD consecutive system clocks. Shorter pulses in either direction have no effect.
- R7: A qualified select while a conversion is pending pulses `conv_abort`, and the stored result is not replaced. A `conv_done` with no conversion pending is ignored.
- R8: With select held low, two cases apply. If no rising edge follows the tenth falling edge within TIMEOUT system clocks, the new result's bit 9 appears on `sdo` once the conversion completes, and a new frame begins. If a rising edge arrives within TIMEOUT, the new bit 9 appears after the sixteenth falling edge, and a new frame begins.
- R9: In the 10-clock case, a rising edge that arrives while the conversion is still pending sets `sync_lost`. `sdo` stays 0 and edges are ignored. `sync_lost` survives deselection and clears only on the next qualified select.
- R10: `conv_done` during a pending conversion stores `conv_data`, and that value is returned by the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host select, active low, asynchronous |
| io_clk | input | 1 | Host serial clock, asynchronous |
| conv_done | input | 1 | Conversion engine finished strobe |
| conv_data | input | DW | Result from the conversion engine |
| sdo | output | 1 | Serial data value |
| sdo_en | output | 1 | Output driver enable, 1 while selected |
| sample_en | output | 1 | Sampling window, edges 3 to 10 |
| conv_start | output | 1 | One-cycle start of conversion (hold instant) |
| conv_abort | output | 1 | One-cycle cancel of a pending conversion |
| sync_lost | output | 1 | Lost-synchronisation state |

## Verification
The assertions assume that each serial clock level and each settled select level lasts several system clocks. Under that assumption, every host edge produces exactly one detected edge, and a reselect can only follow a qualified deselect. They also assume that the engine raises `conv_done` only as a single-cycle strobe. The stimulus holds each serial clock phase for eight system clocks and waits twelve after each select change. Its engine model answers a start after a programmable latency and drops the request on `conv_abort`. Select glitches shorter than the filter, stray done strobes and late clocks are injected on purpose.

// File: rtl/adc_serial_seq.sv
module adc_serial_seq #(
  parameter int DW          = 10,
  parameter int FRAME_MAX   = 16,
  parameter int SAMPLE_EDGE = 3,
  parameter int CS_HOLD     = 3,
  parameter int TIMEOUT     = 64,
  parameter int SYNC        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          io_clk,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  output logic          sdo,
  output logic          sdo_en,
  output logic          sample_en,
  output logic          conv_start,
  output logic          conv_abort,
  output logic          sync_lost
);
  localparam int CW = $clog2(FRAME_MAX + 1);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int HW = $clog2(CS_HOLD + 1);

  typedef enum logic [2:0] {T_IDLE, T_SHIFT, T_WAIT, T_LONG, T_SHORT, T_LOST} tstate_t;

  tstate_t        st;
  logic [SYNC-1:0] io_sh, cs_sh;
  logic           io_d;
  logic           cs_q;
  logic [HW-1:0]  cs_cnt;
  logic [CW-1:0]  cnt;
  logic [TW-1:0]  tcnt;
  logic [DW-1:0]  shreg, result;
  logic           busy;

  wire io_s      = io_sh[SYNC-1];
  wire cs_s      = cs_sh[SYNC-1];
  wire io_fall   = io_d & ~io_s;
  wire io_rise   = ~io_d & io_s;
  wire cs_take   = (cs_s != cs_q) && (cs_cnt == HW'(CS_HOLD - 1));
  wire sel_evt   = cs_take & ~cs_s;
  wire desel_evt = cs_take & cs_s;

  assign sdo_en    = ~cs_q;
  assign sdo       = sdo_en & shreg[DW-1];
  assign sync_lost = (st == T_LOST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_sh <= '0;
      cs_sh <= '1;
      io_d  <= 1'b0;
    end else begin
      io_sh <= {io_sh[SYNC-2:0], io_clk};
      cs_sh <= {cs_sh[SYNC-2:0], cs_n};
      io_d  <= io_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      cs_cnt <= '0;
    end else if (cs_s == cs_q) begin
      cs_cnt <= '0;
    end else if (cs_take) begin
      cs_q   <= cs_s;
      cs_cnt <= '0;
    end else begin
      cs_cnt <= cs_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= T_IDLE;
      cnt        <= '0;
      tcnt       <= '0;
      shreg      <= '0;
      result     <= '0;
      busy       <= 1'b0;
      sample_en  <= 1'b0;
      conv_start <= 1'b0;
      conv_abort <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      conv_abort <= 1'b0;
      if (!sel_evt && busy && conv_done) begin
        result <= conv_data;
        busy   <= 1'b0;
      end
      if (sel_evt) begin
        st        <= T_SHIFT;
        cnt       <= '0;
        shreg     <= result;
        sample_en <= 1'b0;
        if (busy) begin
          busy       <= 1'b0;
          conv_abort <= 1'b1;
        end
      end else if (desel_evt) begin
        sample_en <= 1'b0;
        if (st != T_LOST) st <= T_IDLE;
      end else begin
        case (st)
          T_SHIFT: if (io_fall) begin
            cnt   <= cnt + 1'b1;
            shreg <= {shreg[DW-2:0], 1'b0};
            if (cnt == CW'(SAMPLE_EDGE - 1)) sample_en <= 1'b1;
            if (cnt == CW'(DW - 1)) begin
              sample_en  <= 1'b0;
              conv_start <= 1'b1;
              busy       <= 1'b1;
              tcnt       <= '0;
              st         <= T_WAIT;
            end
          end
          T_WAIT: begin
            if (io_rise)                         st <= T_LONG;
            else if (tcnt == TW'(TIMEOUT - 1))  st <= T_SHORT;
            else                                 tcnt <= tcnt + 1'b1;
          end
          T_LONG: begin
            if (cnt == CW'(FRAME_MAX)) begin
              if (!busy) begin
                st    <= T_SHIFT;
                cnt   <= '0;
                shreg <= result;
              end
            end else if (io_fall) begin
              cnt <= cnt + 1'b1;
            end
          end
          T_SHORT: begin
            if (!busy) begin
              st    <= T_SHIFT;
              cnt   <= '0;
              shreg <= result;
            end else if (io_rise) begin
              st <= T_LOST;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module adc_serial_seq_chk #(
  parameter int FRAME_MAX = 16,
  parameter int CW        = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sdo,
  input logic          sdo_en,
  input logic          sample_en,
  input logic          conv_start,
  input logic          conv_abort,
  input logic          sync_lost,
  input logic [CW-1:0] edge_cnt
);
  p_desel_nosample_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_en |-> !sample_en);
  p_cnt_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= CW'(FRAME_MAX));
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_start_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !sample_en);
  p_window_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sample_en) && sdo_en && $past(sdo_en)) |-> conv_start);
  p_abort_on_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> (sdo_en && !conv_start));
  p_lost_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> !sdo);
  p_lost_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sync_lost) && !$rose(sdo_en)) |-> sync_lost);
endmodule

bind adc_serial_seq adc_serial_seq_chk #(.FRAME_MAX(FRAME_MAX), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .sdo_en(sdo_en), .sample_en(sample_en),
  .conv_start(conv_start), .conv_abort(conv_abort), .sync_lost(sync_lost),
  .edge_cnt(cnt)
);

// File: tb/adc_serial_seq_test.sv
module adc_serial_seq_test;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, io_clk = 1'b0;
  logic conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic sdo, sdo_en, sample_en, conv_start, conv_abort, sync_lost;

  int checks = 0, errors = 0, n_start = 0, n_abort = 0;
  int lat = 20, eng_left = 0;
  logic [9:0] eng_val = '0, prev = '0;
  logic stray_tog = 1'b0, stray_seen = 1'b0;

  always #5 clk = ~clk;

  adc_serial_seq uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io_clk(io_clk),
    .conv_done(conv_done), .conv_data(conv_data), .sdo(sdo), .sdo_en(sdo_en),
    .sample_en(sample_en), .conv_start(conv_start), .conv_abort(conv_abort),
    .sync_lost(sync_lost));

  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) n_start++;
    if (conv_abort) n_abort++;
    if (rst_n) begin
      if (stray_tog != stray_seen) begin
        stray_seen <= stray_tog; conv_done <= 1'b1; conv_data <= 10'h3E1;
      end
      if (conv_abort) eng_left <= 0;
      else if (conv_start) eng_left <= lat;
      else if (eng_left != 0) begin
        eng_left <= eng_left - 1;
        if (eng_left == 1) begin conv_done <= 1'b1; conv_data <= eng_val; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic sel(input logic v); cs_n = v; cyc(12); endtask
  task automatic pulse(); io_clk = 1'b1; cyc(8); io_clk = 1'b0; cyc(8); endtask

  task automatic frame(input int n, input int glitch_at, output logic [9:0] w, output int tbad);
    w = '0; tbad = 0; w[9] = sdo;
    for (int k = 1; k <= n; k++) begin
      pulse();
      if (k < 10) w[9-k] = sdo;
      else if (k < 16 && sdo !== 1'b0) tbad++;
      if (k == glitch_at) begin cs_n = 1'b1; cyc(2); cs_n = 1'b0; cyc(4); end
    end
  endtask

  localparam logic [14:0] VEC [0:5] = '{
    {10'h2A5, 5'd10}, {10'h3FF, 5'd16}, {10'h000, 5'd12},
    {10'h155, 5'd10}, {10'h201, 5'd16}, {10'h0FE, 5'd11}};

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] w;
    int tb, s0, a0;
    bit bad;
    cyc(5); rst_n = 1'b1; cyc(2);
    chk(sdo_en == 0 && sdo == 0, "R1 reset outputs", {sdo_en, sdo}, 0);
    chk(sample_en == 0 && sync_lost == 0 && conv_start == 0, "R1 reset status",
        {sample_en, sync_lost, conv_start}, 0);

    for (int i = 0; i < 6; i++) begin
      eng_val = VEC[i][14:5];
      sel(1'b0);
      frame(int'(VEC[i][4:0]), 0, w, tb);
      chk(w == prev, "R2 R10 frame word", w, prev);
      chk(tb == 0, "R3 zero tail", tb, 0);
      sel(1'b1); cyc(60);
      prev = eng_val;
    end

    s0 = n_start;
    for (int k = 0; k < 5; k++) pulse();
    chk(sdo_en == 0 && sdo == 0, "R1 deselected outputs", {sdo_en, sdo}, 0);
    chk(n_start == s0, "R1 no start while deselected", n_start, s0);
    eng_val = 10'h3C3;
    sel(1'b0); frame(10, 0, w, tb);
    chk(w == prev, "R1 edges ignored, word intact", w, prev);
    sel(1'b1); cyc(60); prev = eng_val;

    eng_val = 10'h1E7;
    sel(1'b0); s0 = n_start; bad = 0;
    for (int k = 1; k <= 10; k++) begin
      pulse();
      if (k < 3 && sample_en !== 1'b0) bad = 1;
      if (k >= 3 && k <= 9 && sample_en !== 1'b1) bad = 1;
      if (k == 9) chk(n_start == s0, "R4 no early start", n_start, s0);
    end
    chk(!bad, "R4 window edges 3..9", bad, 0);
    chk(sample_en == 0, "R4 hold at edge 10", sample_en, 0);
    chk(n_start == s0 + 1, "R4 single start", n_start, s0 + 1);
    sel(1'b1); cyc(60); prev = eng_val;

    s0 = n_start;
    sel(1'b0); for (int k = 0; k < 6; k++) pulse(); sel(1'b1);
    chk(n_start == s0, "R5 short frame no start", n_start, s0);
    eng_val = 10'h099;
    sel(1'b0); frame(10, 0, w, tb);
    chk(w == prev, "R5 result unchanged", w, prev);
    sel(1'b1); cyc(60); prev = eng_val;

    eng_val = 10'h2D2;
    sel(1'b0); frame(10, 4, w, tb);
    chk(w == prev, "R6 high glitch ignored", w, prev);
    sel(1'b1); cyc(60); prev = eng_val;
    bad = 0; cs_n = 1'b0; cyc(2); cs_n = 1'b1;
    for (int k = 0; k < 12; k++) begin cyc(1); if (sdo_en !== 1'b0) bad = 1; end
    chk(!bad, "R6 low glitch ignored", bad, 0);

    lat = 200; eng_val = 10'h111;
    sel(1'b0); frame(10, 0, w, tb);
    chk(w == prev, "R7 frame before abort", w, prev);
    sel(1'b1); a0 = n_abort; eng_val = 10'h0AB;
    sel(1'b0);
    chk(n_abort == a0 + 1, "R7 abort pulse", n_abort, a0 + 1);
    frame(10, 0, w, tb);
    chk(w == prev, "R7 aborted result kept", w, prev);
    sel(1'b1); cyc(250); prev = eng_val; lat = 20;
    stray_tog = ~stray_tog; cyc(10);
    eng_val = 10'h35A;
    sel(1'b0); frame(10, 0, w, tb);
    chk(w == prev, "R7 stray done ignored", w, prev);

    cyc(120);
    chk(sdo == 1'b1 && sdo_en == 1'b1, "R8 short auto MSB", sdo, 1);
    eng_val = 10'h2C4;
    frame(10, 0, w, tb);
    chk(w == 10'h35A, "R8 continuous 10-clock word", w, 10'h35A);
    cyc(120);
    eng_val = 10'h3A0;
    frame(16, 0, w, tb);
    chk(w == 10'h2C4 && tb == 0, "R8 continuous 16-clock word", w, 10'h2C4);
    chk(sdo == 1'b1, "R8 MSB at sixteenth edge", sdo, 1);
    eng_val = 10'h155;
    frame(16, 0, w, tb);
    chk(w == 10'h3A0, "R8 second 16-clock word", w, 10'h3A0);
    chk(sdo == 1'b0, "R8 new MSB zero", sdo, 0);
    sel(1'b1); cyc(60); prev = 10'h155;

    lat = 300; eng_val = 10'h3FF;
    sel(1'b0); frame(10, 0, w, tb);
    chk(w == prev, "R9 frame before late clock", w, prev);
    cyc(100); pulse();
    chk(sync_lost == 1'b1, "R9 lost on late edge", sync_lost, 1);
    bad = 0;
    for (int k = 0; k < 3; k++) begin pulse(); if (sdo !== 1'b0) bad = 1; end
    chk(!bad && sync_lost, "R9 quiet while lost", {bad, sync_lost}, 1);
    sel(1'b1);
    chk(sync_lost == 1'b1, "R9 survives deselect", sync_lost, 1);
    lat = 20; eng_val = 10'h0C3;
    sel(1'b0);
    chk(sync_lost == 1'b0, "R9 cleared by reselect", sync_lost, 0);
    frame(10, 0, w, tb);
    chk(w == prev, "R9 R7 recovered word", w, prev);
    sel(1'b1); cyc(60);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule